// File: doc/BRIEF.md
# Flash Bus Write-Cycle Capture

This block is the device side of an asynchronous parallel NOR-style flash bus, rebuilt inside one system clock domain. The four active-low bus controls (chip enable, write enable, output enable and the hardware reset pin) pass through a two-flop synchroniser together with the 22-bit word address and the 16-bit data word. The block then recovers the bus edges from the synchronised values. A write cycle exists only while chip enable and write enable are both low and output enable is high. The address is taken on the falling edge that completes that low condition. The data word is taken on the rising edge that first breaks it. Each completed write leaves the block as a one-cycle command strobe that carries the captured address and data to a command decoder downstream.

The reset pin is qualified. A low level of at least a parameterised number of clocks aborts any write that is half done and tells the decoder to go back to read-array mode with a one-cycle pulse. It also sets a sticky abort flag when work was in progress. Shorter low pulses are treated as glitches. While the reset pin is low, all bus activity is ignored and the data-bus output enable stays off. The command strobe has no ready input, because a flash bus cannot be stalled. The consumer must accept every strobe in the cycle it appears. The bus itself guarantees at least three clocks between strobes.

Top module: `flash_wr_capture`

## Requirements
- R1: While the system reset rst_n is low, and just after it is released, cmd_valid, dq_oe, rd_array_rst and abort_flag are 0, and cmd_addr and cmd_data are all zeros.
- R2: cmd_addr holds the address pins as seen at the later of the two falling edges of ce_n and we_n. Address changes before that edge, and changes after it, do not affect the value.
- R3: cmd_data holds the data pins as seen at the earlier of the two rising edges of ce_n and we_n. Data changes after that edge do not affect the value.
- R4: Each complete write produces exactly one cmd_valid pulse, one clock long. It appears in the third clock after the pin sample that shows the end edge. Falling or rising of ce_n and we_n in the same sample counts as a single edge.
- R5: If oe_n is low when the low condition starts, or when it ends, that write produces no cmd_valid.
- R6: dq_oe is 1 exactly when, three clocks earlier, the pins were sampled with ce_n=0, oe_n=0, we_n=1 and hw_reset_n=1.
- R7: While hw_reset_n is low, write edges produce no command and dq_oe is 0.
- R8: A hw_reset_n low level lasting MIN_PULSE synchronised clocks or more gives exactly one rd_array_rst pulse, one clock long. A write whose address was already captured is discarded.
- R9: A hw_reset_n low level shorter than MIN_PULSE clocks produces no rd_array_rst pulse and does not set abort_flag.
- R10: abort_flag becomes 1 on a qualified reset when op_busy is 1 or a write is half done. It then stays 1 until rst_n goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| ce_n | input | 1 | Bus chip enable pin, active low |
| we_n | input | 1 | Bus write enable pin, active low |
| oe_n | input | 1 | Bus output enable pin, active low |
| hw_reset_n | input | 1 | Bus hardware reset pin, active low |
| addr_pin | input | ADDR_W (22) | Word address pins |
| data_pin | input | DATA_W (16) | Data pins as driven by the host |
| op_busy | input | 1 | Downstream operation in progress |
| cmd_valid | output | 1 | One-cycle strobe for a completed write |
| cmd_addr | output | ADDR_W (22) | Captured write address |
| cmd_data | output | DATA_W (16) | Captured write data |
| dq_oe | output | 1 | Data bus output enable |
| rd_array_rst | output | 1 | One-cycle request to return to read-array mode |
| abort_flag | output | 1 | Sticky flag: a qualified reset hit active work |

## Verification
Writes are driven with write enable falling first and with chip enable falling first. They are ended by either strobe rising first, and by both strobes moving in the same sample. The address and data pins change during every phase of each write, so the capture edge is identified and a design that takes the first fall or the last rise is exposed. Output enable is brought low at the start and, separately, at the end of a write, which separates the two ignore rules. Reset pulses one clock short of the minimum width, reset pulses well above it, and reset pulses that land in the middle of an armed write or while op_busy is high tell the glitch filter apart from the abort path and from the sticky flag.

// File: rtl/flash_cap_pkg.sv
package flash_cap_pkg;

  localparam int unsigned FC_ADDR_W    = 22;
  localparam int unsigned FC_DATA_W    = 16;
  localparam int unsigned FC_SYNC_DEPTH = 2;

  // Synchronised view of the four active-low control pins.
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic rp_n;
  } fc_ctl_t;

  localparam int unsigned FC_CTL_W = $bits(fc_ctl_t);
  localparam fc_ctl_t     FC_CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, rp_n: 1'b1};

  typedef enum logic [0:0] {
    PH_IDLE  = 1'b0,
    PH_ARMED = 1'b1
  } fc_phase_t;

endpackage

// File: rtl/fc_pin_sync.sv
module fc_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= RST_VAL;
        else        stage_q[gi] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= RST_VAL;
        else        stage_q[gi] <= stage_q[gi-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/fc_reset_qual.sv
module fc_reset_qual #(
  parameter int unsigned MIN_PULSE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic qual_now,
  output logic rd_rst
);

  localparam int unsigned CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MIN_PULSE);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(MIN_PULSE - 1);

  logic [CNT_W-1:0] low_cnt;

  // Fires in the single cycle in which the low level reaches the minimum width.
  assign qual_now = !pin_n && (low_cnt == CNT_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      rd_rst  <= 1'b0;
    end else begin
      rd_rst <= qual_now;
      if (pin_n)                   low_cnt <= '0;
      else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fc_write_capture.sv
module fc_write_capture
  import flash_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = FC_ADDR_W,
  parameter int unsigned DATA_W = FC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fc_ctl_t           ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              qual_now,
  input  logic              op_busy,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              abort_flag
);

  fc_phase_t         phase;
  logic              prev_low;
  logic [ADDR_W-1:0] addr_hold;
  logic              low_now;
  logic              start_edge;
  logic              end_edge;
  logic              bus_live;

  assign low_now    = !ctl.ce_n && !ctl.we_n;
  assign start_edge = low_now && !prev_low;
  assign end_edge   = !low_now && prev_low;
  assign bus_live   = ctl.rp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      prev_low   <= 1'b0;
      addr_hold  <= '0;
      cmd_valid  <= 1'b0;
      cmd_addr   <= '0;
      cmd_data   <= '0;
      abort_flag <= 1'b0;
    end else begin
      prev_low  <= low_now;
      cmd_valid <= 1'b0;
      if (qual_now) begin
        abort_flag <= abort_flag | op_busy | (phase == PH_ARMED);
        phase      <= PH_IDLE;
      end else if (bus_live) begin
        if (start_edge) begin
          if (ctl.oe_n) begin
            phase     <= PH_ARMED;
            addr_hold <= addr;
          end else begin
            phase <= PH_IDLE;
          end
        end else if (end_edge) begin
          if (phase == PH_ARMED && ctl.oe_n) begin
            cmd_valid <= 1'b1;
            cmd_addr  <= addr_hold;
            cmd_data  <= data;
          end
          phase <= PH_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/flash_wr_capture.sv
module flash_wr_capture
  import flash_cap_pkg::*;
#(
  parameter int unsigned ADDR_W      = FC_ADDR_W,
  parameter int unsigned DATA_W      = FC_DATA_W,
  parameter int unsigned SYNC_STAGES = FC_SYNC_DEPTH,
  parameter int unsigned MIN_PULSE   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              hw_reset_n,
  input  logic [ADDR_W-1:0] addr_pin,
  input  logic [DATA_W-1:0] data_pin,
  input  logic              op_busy,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              dq_oe,
  output logic              rd_array_rst,
  output logic              abort_flag
);

  localparam int unsigned BUS_W = FC_CTL_W + ADDR_W + DATA_W;
  localparam logic [BUS_W-1:0] BUS_IDLE = {FC_CTL_IDLE, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

  logic [BUS_W-1:0]  raw_bus;
  logic [BUS_W-1:0]  syn_bus;
  fc_ctl_t           syn_ctl;
  logic [ADDR_W-1:0] syn_addr;
  logic [DATA_W-1:0] syn_data;
  logic              qual_now;

  assign raw_bus = {ce_n, we_n, oe_n, hw_reset_n, addr_pin, data_pin};

  fc_pin_sync #(
    .WIDTH  (BUS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(BUS_IDLE)
  ) u_sync (
    .clk (clk),
    .rst_n(rst_n),
    .din (raw_bus),
    .dout(syn_bus)
  );

  assign syn_ctl  = fc_ctl_t'(syn_bus[BUS_W-1 -: FC_CTL_W]);
  assign syn_addr = syn_bus[DATA_W +: ADDR_W];
  assign syn_data = syn_bus[DATA_W-1:0];

  fc_reset_qual #(
    .MIN_PULSE(MIN_PULSE)
  ) u_rq (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   (syn_ctl.rp_n),
    .qual_now(qual_now),
    .rd_rst  (rd_array_rst)
  );

  fc_write_capture #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_wc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (syn_ctl),
    .addr      (syn_addr),
    .data      (syn_data),
    .qual_now  (qual_now),
    .op_busy   (op_busy),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .abort_flag(abort_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dq_oe <= 1'b0;
    else        dq_oe <= !syn_ctl.ce_n && !syn_ctl.oe_n && syn_ctl.we_n && syn_ctl.rp_n;
  end

endmodule

// File: rtl/flash_wr_capture_chk.sv
module flash_wr_capture_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic hw_reset_n,
  input logic cmd_valid,
  input logic dq_oe,
  input logic rd_array_rst,
  input logic abort_flag
);

  assert_cmd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_oe_pins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!$past(ce_n, 3) && !$past(oe_n, 3) && $past(we_n, 3) && $past(hw_reset_n, 3)));

  assert_no_cmd_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(hw_reset_n, 3));

  assert_rd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_array_rst |=> !rd_array_rst);

  assert_rd_no_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_array_rst |-> !cmd_valid);

  assert_rd_pin_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_array_rst |-> !$past(hw_reset_n, 3));

  assert_abort_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_flag |=> abort_flag);

endmodule

bind flash_wr_capture flash_wr_capture_chk u_chk (.*);

// File: tb/flash_wr_capture_test.sv
module flash_wr_capture_test;

  localparam int MINP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, hw_reset_n = 1'b1;
  logic [21:0] addr_pin = '0;
  logic [15:0] data_pin = '0;
  logic        op_busy = 1'b0;
  logic        cmd_valid, dq_oe, rd_array_rst, abort_flag;
  logic [21:0] cmd_addr;
  logic [15:0] cmd_data;

  int n_cmp = 0;
  int n_bad = 0;
  int dut_cmd_cnt = 0;
  int dut_rd_cnt = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_wr_capture #(.MIN_PULSE(MINP)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .hw_reset_n(hw_reset_n), .addr_pin(addr_pin), .data_pin(data_pin),
    .op_busy(op_busy), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .dq_oe(dq_oe), .rd_array_rst(rd_array_rst),
    .abort_flag(abort_flag)
  );

  // ---------------- behavioural reference model ----------------
  typedef struct {
    logic ce, we, oe, rp;
    logic [21:0] a;
    logic [15:0] d;
  } smp_t;

  smp_t hist[$];
  bit          m_armed;
  logic [21:0] m_addr_l;
  int          m_cnt;
  logic        m_valid, m_oe, m_rd, m_abort;
  logic [21:0] m_addr;
  logic [15:0] m_data;

  function automatic smp_t idle_smp();
    smp_t s;
    s.ce = 1; s.we = 1; s.oe = 1; s.rp = 1; s.a = '0; s.d = '0;
    return s;
  endfunction

  task automatic model_reset();
    hist.delete();
    repeat (3) hist.push_back(idle_smp());
    m_armed = 0; m_addr_l = '0; m_cnt = 0;
    m_valid = 0; m_oe = 0; m_rd = 0; m_abort = 0; m_addr = '0; m_data = '0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
      started = 1;
    end else if (started) begin
      smp_t cur, s, p;
      bit qual, lown, lowp;
      cur.ce = ce_n; cur.we = we_n; cur.oe = oe_n; cur.rp = hw_reset_n;
      cur.a = addr_pin; cur.d = data_pin;
      hist.push_back(cur);
      while (hist.size() > 4) void'(hist.pop_front());
      s = hist[hist.size()-3];
      p = hist[hist.size()-4];
      qual = !s.rp && (m_cnt == MINP-1);
      if (s.rp) m_cnt = 0; else if (m_cnt < MINP) m_cnt++;
      m_rd = qual;
      m_oe = !s.ce && !s.oe && s.we && s.rp;
      m_valid = 0;
      lown = !s.ce && !s.we;
      lowp = !p.ce && !p.we;
      if (qual) begin
        m_abort = m_abort | op_busy | m_armed;
        m_armed = 0;
      end else if (s.rp) begin
        if (lown && !lowp) begin
          m_armed = s.oe;
          if (s.oe) m_addr_l = s.a;
        end else if (!lown && lowp) begin
          if (m_armed && s.oe) begin
            m_valid = 1; m_addr = m_addr_l; m_data = s.d;
          end
          m_armed = 0;
        end
      end
    end
  end

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && started && !done) begin
      cmp("R4", "cmd_valid", 32'(cmd_valid), 32'(m_valid));
      cmp("R2", "cmd_addr", 32'(cmd_addr), 32'(m_addr));
      cmp("R3", "cmd_data", 32'(cmd_data), 32'(m_data));
      cmp("R6", "dq_oe", 32'(dq_oe), 32'(m_oe));
      cmp("R8", "rd_array_rst", 32'(rd_array_rst), 32'(m_rd));
      cmp("R10", "abort_flag", 32'(abort_flag), 32'(m_abort));
      if (cmd_valid) dut_cmd_cnt++;
      if (rd_array_rst) dut_rd_cnt++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int c0, r0;
    step(3);
    // R1: reset values while rst_n low
    cmp("R1", "cmd_valid rst", 32'(cmd_valid), 0);
    cmp("R1", "dq_oe rst", 32'(dq_oe), 0);
    cmp("R1", "abort rst", 32'(abort_flag), 0);
    cmp("R1", "addr/data rst", {cmd_addr[15:0], cmd_data}, 0);
    rst_n = 1;
    step(4);
    cmp("R1", "rd_array_rst after rst", 32'(rd_array_rst), 0);

    // R2/R3: WE falls first, CE completes; CE rises first
    c0 = dut_cmd_cnt;
    addr_pin = 22'h0A5C1F; we_n = 0; step(3);
    addr_pin = 22'h2B3D4E; step(3);
    ce_n = 0; step(3);
    addr_pin = 22'h3FFFFF; data_pin = 16'hBEEF; step(3);
    ce_n = 1; step(3);
    data_pin = 16'h1111; step(3);
    we_n = 1; step(6);
    cmp("R2", "later-fall address", 32'(cmd_addr), 32'h2B3D4E);
    cmp("R3", "earlier-rise data", 32'(cmd_data), 32'hBEEF);
    cmp("R4", "one pulse per write", dut_cmd_cnt - c0, 1);

    // CE falls first, WE completes; WE rises first
    c0 = dut_cmd_cnt;
    addr_pin = 22'h111111; ce_n = 0; step(3);
    addr_pin = 22'h1C0DE5; we_n = 0; step(3);
    addr_pin = 22'h000001; data_pin = 16'h5A5A; step(3);
    we_n = 1; step(2);
    data_pin = 16'hFFFF; step(3);
    ce_n = 1; step(6);
    cmp("R2", "WE-completed address", 32'(cmd_addr), 32'h1C0DE5);
    cmp("R3", "WE-ended data", 32'(cmd_data), 32'h5A5A);
    cmp("R4", "one pulse second write", dut_cmd_cnt - c0, 1);

    // Simultaneous edges
    c0 = dut_cmd_cnt;
    addr_pin = 22'h3C3C3C; ce_n = 0; we_n = 0; step(4);
    data_pin = 16'h0F0F; step(2);
    ce_n = 1; we_n = 1; step(6);
    cmp("R4", "simultaneous edges single pulse", dut_cmd_cnt - c0, 1);
    cmp("R2", "simultaneous address", 32'(cmd_addr), 32'h3C3C3C);

    // R5: OE low at start, then OE low at end
    c0 = dut_cmd_cnt;
    oe_n = 0; step(3); ce_n = 0; we_n = 0; step(3); oe_n = 1; step(3);
    ce_n = 1; we_n = 1; step(5);
    ce_n = 0; we_n = 0; step(3); oe_n = 0; step(3);
    ce_n = 1; we_n = 1; step(3); oe_n = 1; step(5);
    cmp("R5", "OE-low writes ignored", dut_cmd_cnt - c0, 0);

    // R6: read cycle drives output enable
    ce_n = 0; oe_n = 0; step(5);
    cmp("R6", "read cycle dq_oe", 32'(dq_oe), 1);
    // R7/R9: short glitch during read turns dq_oe off, no reset pulse
    r0 = dut_rd_cnt;
    hw_reset_n = 0; step(MINP-1);
    cmp("R7", "dq_oe off while reset pin low", 32'(dq_oe), 0);
    hw_reset_n = 1; step(6);
    cmp("R9", "glitch gives no rd pulse", dut_rd_cnt - r0, 0);
    cmp("R9", "glitch leaves abort clear", 32'(abort_flag), 0);
    ce_n = 1; oe_n = 1; step(4);

    // R7/R8: write attempted under long reset
    c0 = dut_cmd_cnt; r0 = dut_rd_cnt;
    hw_reset_n = 0; step(3);
    ce_n = 0; we_n = 0; step(4); ce_n = 1; we_n = 1; step(10);
    hw_reset_n = 1; step(6);
    cmp("R7", "write under reset ignored", dut_cmd_cnt - c0, 0);
    cmp("R8", "long reset one rd pulse", dut_rd_cnt - r0, 1);
    cmp("R10", "idle reset leaves abort clear", 32'(abort_flag), 0);

    // R8/R10: reset lands in an armed write
    c0 = dut_cmd_cnt;
    addr_pin = 22'h155555; ce_n = 0; we_n = 0; step(4);
    hw_reset_n = 0; step(MINP + 4); hw_reset_n = 1; step(4);
    ce_n = 1; we_n = 1; step(6);
    cmp("R8", "armed write discarded", dut_cmd_cnt - c0, 0);
    cmp("R10", "abort set on armed write", 32'(abort_flag), 1);
    c0 = dut_cmd_cnt;
    ce_n = 0; we_n = 0; step(3); ce_n = 1; we_n = 1; step(6);
    cmp("R10", "abort stays after new write", 32'(abort_flag), 1);
    cmp("R4", "write after abort works", dut_cmd_cnt - c0, 1);

    // R10: busy-only abort after clearing with rst_n
    rst_n = 0; step(2);
    cmp("R10", "rst_n clears abort", 32'(abort_flag), 0);
    rst_n = 1; step(3);
    op_busy = 1; hw_reset_n = 0; step(MINP + 3); hw_reset_n = 1; op_busy = 0; step(5);
    cmp("R10", "busy abort", 32'(abort_flag), 1);

    done = 1;
    summary();
    $finish;
  end

endmodule